// File: doc/BRIEF.md
# Hardware Capture Period Meter

This block measures the time between two successive edges of one chosen polarity on a single digital input. A shared timer clock is formed by dividing the system clock by a programmable amount, and that divided rate advances a free-running capture counter (16 bits by default). When a qualifying edge arrives, the counter value is latched in hardware. The difference from the previously latched value is published as the period, so the result is exact to one timer tick and no handling delay is added.

The input is asynchronous, so it passes through a two-flop synchroniser before edge detection. One control bit chooses between rising-to-rising and falling-to-falling timing, and edges of the other polarity are ignored. Enabling the meter arms it. The first qualifying edge after enable only records a reference time, and every later edge publishes a period with a one-cycle valid strobe. Periods longer than the counter range are not flagged; they fold modulo the counter range.

Top module: `period_capture_meter`

## Requirements
- R1: While reset is held and after its release, `period` reads 0 and `period_valid` reads 0 until a period is measured.
- R2: With `falling_sel` = 0, each rising edge of `sig_in` after the first publishes the number of timer ticks since the previous rising edge; falling edges publish nothing.
- R3: With `falling_sel` = 1, each falling edge of `sig_in` after the first publishes the number of timer ticks since the previous falling edge; rising edges publish nothing.
- R4: The timer tick occurs once every `tick_div`+1 system clocks, so a value of 0 counts system clocks directly.
- R5: The first qualifying edge after `enable` rises only records a reference time and raises no `period_valid`.
- R6: While `enable` is 0, no period is published, `period` keeps its last value, and the reference time is discarded.
- R7: The period is the later capture minus the earlier one modulo 2^CNT_W, so a counter wrap between captures is handled, and a spacing longer than 2^CNT_W ticks folds to its remainder.
- R8: `period_valid` is high for exactly one system clock per published period, and `period` changes only in a cycle where `period_valid` is high.
- R9: A qualifying edge driven on `sig_in` before clock edge k raises `period_valid` after clock edge k+2 (two synchroniser stages plus the capture register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the base of the timer clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Arms the meter; low discards the reference time |
| falling_sel | input | 1 | 0: time rising edges, 1: time falling edges |
| tick_div | input | DIV_W | Timer clock divisor minus one, shared with other timers |
| sig_in | input | 1 | Asynchronous signal under measurement |
| period | output | CNT_W | Last published period in timer ticks |
| period_valid | output | 1 | One-cycle strobe marking a new period |

## Verification
The bench builds the meter with CNT_W = 12 and DIV_W = 4. The narrower counter wraps after 4096 ticks, so both a wrap between two captures and a period longer than the counter range can be checked in a few thousand cycles. The divisor is set to 0 for exact clock-count checks and to 4 to show tick scaling. A reference model of the tick counter, the synchroniser delay and the capture rules is compared with both outputs on every clock.

// File: rtl/period_capture_meter.sv
module period_capture_meter #(
  parameter int CNT_W = 16,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             falling_sel,
  input  logic [DIV_W-1:0] tick_div,
  input  logic             sig_in,
  output logic [CNT_W-1:0] period,
  output logic             period_valid
);

  logic [DIV_W-1:0] pre_cnt;
  logic             tick;
  logic [CNT_W-1:0] timebase;
  logic [CNT_W-1:0] last_cap;
  logic [2:0]       sync_q;
  logic             armed;
  logic             hit;

  assign tick = (pre_cnt >= tick_div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pre_cnt <= '0;
    else if (tick) pre_cnt <= '0;
    else           pre_cnt <= pre_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    timebase <= '0;
    else if (tick) timebase <= timebase + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], sig_in};
  end

  assign hit = falling_sel ? (sync_q[2] & ~sync_q[1]) : (~sync_q[2] & sync_q[1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed        <= 1'b0;
      last_cap     <= '0;
      period       <= '0;
      period_valid <= 1'b0;
    end else begin
      period_valid <= 1'b0;
      if (!enable) begin
        armed <= 1'b0;
      end else if (hit) begin
        last_cap <= timebase;
        armed    <= 1'b1;
        if (armed) begin
          period       <= timebase - last_cap;
          period_valid <= 1'b1;
        end
      end
    end
  end

  assert_tick_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (timebase == $past(timebase)) || (timebase == $past(timebase) + 1'b1));

  assert_primed_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    period_valid |-> $past(armed));

  assert_idle_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(enable) |-> !period_valid);

  assert_valid_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    period_valid |=> !period_valid);

  assert_period_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !period_valid |-> $stable(period));

endmodule

// File: tb/test_period_capture_meter.sv
module test_period_capture_meter;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 12;
  localparam int DW = 4;
  localparam int MASK = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enable = 1'b0;
  logic          falling_sel = 1'b0;
  logic [DW-1:0] tick_div = '0;
  logic          sig_in = 1'b0;
  logic [CW-1:0] period;
  logic          period_valid;

  int errors = 0;
  int checks = 0;

  period_capture_meter #(.CNT_W(CW), .DIV_W(DW)) i_period_capture_meter (
    .clk(clk), .rst_n(rst_n), .enable(enable), .falling_sel(falling_sel),
    .tick_div(tick_div), .sig_in(sig_in), .period(period), .period_valid(period_valid));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  int  m_time = 0, m_divc = 0, m_prev = 0, m_per = 0;
  bit  m_valid = 0, m_primed = 0;
  bit  hist[$] = '{0, 0, 0};

  always @(posedge clk) begin
    bit older, newer, edge_seen;
    if (!rst_n) begin
      m_time = 0; m_divc = 0; m_prev = 0; m_per = 0;
      m_valid = 0; m_primed = 0; hist = '{0, 0, 0};
    end else begin
      newer = hist[1];
      older = hist[2];
      edge_seen = falling_sel ? (older && !newer) : (!older && newer);
      m_valid = 0;
      if (!enable) m_primed = 0;
      else if (edge_seen) begin
        if (m_primed) begin
          m_per = (m_time - m_prev) & MASK;
          m_valid = 1;
        end
        m_prev = m_time;
        m_primed = 1;
      end
      if (m_divc >= int'(tick_div)) begin
        m_divc = 0;
        m_time = (m_time + 1) & MASK;
      end else m_divc++;
      hist.push_front(sig_in);
      void'(hist.pop_back());
    end
  end

  int got[$];
  always @(negedge clk) begin
    if (rst_n) begin
      chk(period_valid == m_valid, "R8 valid strobe vs model", period_valid, m_valid);
      chk(int'(period) == m_per, "R8 period vs model", period, m_per);
      if (period_valid) got.push_back(int'(period));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulses(input int n, input int hi, input int lo);
    for (int i = 0; i < n; i++) begin
      sig_in = 1'b1; cyc(hi);
      sig_in = 1'b0; cyc(lo);
    end
  endtask

  task automatic rearm(input bit fall, input int dv);
    enable = 1'b0; falling_sel = fall; tick_div = DW'(dv);
    cyc(4);
    got.delete();
    enable = 1'b1;
    cyc(2);
  endtask

  task automatic expect_list(input string tag, input int n, input int val);
    chk(got.size() == n, {tag, " count"}, got.size(), n);
    foreach (got[i]) chk(got[i] == val, {tag, " value"}, got[i], val);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cyc(3);
    chk(period == 0, "R1 period in reset", period, 0);
    chk(period_valid == 0, "R1 valid in reset", period_valid, 0);
    rst_n = 1'b1;
    cyc(2);
    chk(period == 0, "R1 period after reset", period, 0);
    chk(period_valid == 0, "R1 valid after reset", period_valid, 0);

    // R2 and R5: rising spacing 10 clocks, first edge only primes
    rearm(0, 0);
    pulses(4, 3, 7);
    cyc(4);
    expect_list("R2/R5 rising", 3, 10);

    // R3: falling spacing 13 clocks
    rearm(1, 0);
    pulses(4, 4, 9);
    cyc(4);
    expect_list("R3 falling", 3, 13);

    // R4: divisor 4 -> 5 clocks per tick, 25 clocks -> 5 ticks
    rearm(0, 4);
    pulses(4, 10, 15);
    cyc(4);
    expect_list("R4 divided ticks", 3, 5);

    // R6: disabled meter ignores edges, keeps last value
    enable = 1'b0;
    cyc(3);
    got.delete();
    pulses(3, 4, 6);
    cyc(4);
    chk(got.size() == 0, "R6 no valid while disabled", got.size(), 0);
    chk(period == 5, "R6 period held while disabled", period, 5);

    // R7: wrap crossing and folding beyond range
    rearm(0, 0);
    pulses(4, 100, 2900);
    cyc(4);
    expect_list("R7 wrap crossing", 3, 3000);
    rearm(0, 0);
    pulses(3, 50, 4096 + 7 - 50);
    cyc(4);
    expect_list("R7 fold beyond range", 2, 7);

    // R9: latency from drive to strobe
    rearm(0, 0);
    pulses(1, 5, 6);
    sig_in = 1'b1;
    cyc(1);
    chk(period_valid == 0, "R9 no strobe after 1 clock", period_valid, 0);
    cyc(1);
    chk(period_valid == 0, "R9 no strobe after 2 clocks", period_valid, 0);
    cyc(1);
    chk(period_valid == 1, "R9 strobe after 3 clocks", period_valid, 1);
    chk(period == 11, "R9 period value", period, 11);
    cyc(1);
    chk(period_valid == 0, "R8 strobe lasts one clock", period_valid, 0);
    sig_in = 1'b0;
    cyc(5);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule